// File: doc/BRIEF.md
# Restartable Contact Debouncer

This block cleans up 32 contact inputs that have already been synchronised to the local clock. Every channel holds a reported level. A channel adopts a new level only after its raw input has differed from the reported level, without interruption, for a whole stability period. If the raw input falls back to the reported level before the period is over, the channel's progress is discarded. The next difference must then last a full period from its own start.

All channels share one stability period. A 3-bit code picks it from eight settings that grow roughly in powers of two. The shortest setting is only a couple of ticks long, so it acts as a near bypass for users who care more about latency than about bounce rejection. Periods are counted in ticks of an internal prescaler that divides the clock by `TICK_DIV`. Each channel marks every accepted transition with a one-cycle event pulse, which a downstream scanner can use to log changes.

Top module: `contact_debouncer`

## Requirements
- R1: While `rst` is high and after it is released, `level_o` and `event_o` are all zero, and every channel's progress is cleared. A channel whose raw input differs after reset needs a full period before it reports.
- R2: If a channel's raw input returns to the reported level before the period has been completed, its progress restarts. Differences that are each shorter than one period never change the reported level, however long they add up to.
- R3: Once `raw_i[i]` differs from `level_o[i]` and keeps that value, `level_o[i]` takes the raw value after N prescaler ticks. This is no earlier than (N-1)*TICK_DIV clock cycles after the change and no later than N*TICK_DIV+2 cycles after it.
- R4: `period_sel_i` codes 0 to 7 give N = BASE_TICKS times 1, 2, 4, 8, 32, 128, 512 and 4096 ticks respectively. Code 0 is the shortest setting and acts as a near bypass.
- R5: A single period applies to all channels together. A new `period_sel_i` takes effect within two clock cycles, including for channels that are already part way through a period.
- R6: `event_o[i]` is high for exactly one cycle, in the same cycle in which `level_o[i]` changes, and is low in every other cycle.
- R7: `level_o[i]` only ever changes towards the value that `raw_i[i]` had in the previous cycle. A channel whose raw input equals its reported level keeps that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_sel_i | input | 3 | Shared stability-period code (0 shortest, 7 longest) |
| raw_i | input | NUM_CH | Synchronised raw contact levels |
| level_o | output | NUM_CH | Debounced reported levels |
| event_o | output | NUM_CH | One-cycle pulse on each accepted transition |

## Verification
The hardest situation to reach is a train of bounces whose total length is well beyond one period, where every single bounce is shorter than the period. A timer that failed to restart would report a level here, so the bench alternates a channel between long excursions and two-cycle returns, and only then holds the new level. A second hard case is a period change while a channel is in the middle of a long window. The bench starts a channel under the longest code and switches to the shortest code partway through, then checks that the report follows within a few ticks.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

    localparam int PERIOD_CODE_W = 3;
    localparam int MAX_SHIFT     = 12;

    typedef logic [PERIOD_CODE_W-1:0] period_code_t;

    // Result of one channel in one cycle.
    typedef struct packed {
        logic level;
        logic pulse;
    } chan_state_t;

    // Power-of-two multiplier of the base tick count for each code.
    function automatic int unsigned period_shift(period_code_t code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 1;
            3'd2:    return 2;
            3'd3:    return 3;
            3'd4:    return 5;
            3'd5:    return 7;
            3'd6:    return 9;
            default: return MAX_SHIFT;
        endcase
    endfunction

    // Final counter value (ticks minus one) for a code.
    function automatic int unsigned last_count(period_code_t code, int unsigned base);
        return (base << period_shift(code)) - 1;
    endfunction

endpackage

// File: rtl/dbn_tick_gen.sv
module dbn_tick_gen #(
    parameter int TICK_DIV = 438
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick_o = (pre_q == PRE_LAST);

endmodule

// File: rtl/dbn_period_dec.sv
module dbn_period_dec
    import dbn_pkg::*;
#(
    parameter int BASE_TICKS = 1,
    parameter int CNT_W      = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  period_code_t      code_i,
    output logic [CNT_W-1:0]  last_o
);
    logic [CNT_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= CNT_W'(last_count(3'd0, BASE_TICKS));
        end else begin
            last_q <= CNT_W'(last_count(code_i, BASE_TICKS));
        end
    end

    assign last_o = last_q;

endmodule

// File: rtl/dbn_channel.sv
module dbn_channel
    import dbn_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [CNT_W-1:0]  last_i,
    input  logic              raw_i,
    output chan_state_t       state_o
);
    chan_state_t      st_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            cnt_q <= '0;
        end else begin
            st_q.pulse <= 1'b0;
            if (raw_i == st_q.level) begin
                // Agreement (or a bounce back) discards any progress.
                cnt_q <= '0;
            end else if (tick_i) begin
                if (cnt_q >= last_i) begin
                    st_q.level <= raw_i;
                    st_q.pulse <= 1'b1;
                    cnt_q      <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/contact_debouncer.sv
module contact_debouncer
    import dbn_pkg::*;
#(
    parameter int NUM_CH     = 32,
    parameter int TICK_DIV   = 438,
    parameter int BASE_TICKS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        period_sel_i,
    input  logic [NUM_CH-1:0] raw_i,
    output logic [NUM_CH-1:0] level_o,
    output logic [NUM_CH-1:0] event_o
);
    localparam int MAX_TICKS = BASE_TICKS << MAX_SHIFT;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic             tick;
    logic [CNT_W-1:0] last_cnt;

    dbn_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    dbn_period_dec #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .code_i (period_sel_i),
        .last_o (last_cnt)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        chan_state_t st;

        dbn_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick_i  (tick),
            .last_i  (last_cnt),
            .raw_i   (raw_i[i]),
            .state_o (st)
        );

        assign level_o[i] = st.level;
        assign event_o[i] = st.pulse;
    end

endmodule

// File: rtl/contact_debouncer_chk.sv
module contact_debouncer_chk #(
    parameter int NUM_CH = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] raw_i,
    input logic [NUM_CH-1:0] level_o,
    input logic [NUM_CH-1:0] event_o
);
    logic rst_seen;

    always_ff @(posedge clk) rst_seen <= rst;

    // R1: outputs are cleared once reset has been sampled.
    always @(negedge clk) begin
        if (rst_seen && rst) begin
            p_reset_clears_r1: assert (level_o == '0 && event_o == '0);
        end
    end

    // R6: the event pulse marks exactly the bits whose level moved.
    p_event_marks_change_r6: assert property (@(posedge clk) disable iff (rst)
        (level_o ^ $past(level_o)) == event_o);

    // R7: a level can only move to the raw value seen in the previous cycle.
    p_moves_toward_raw_r7: assert property (@(posedge clk) disable iff (rst)
        ((level_o ^ $past(level_o)) & (level_o ^ $past(raw_i))) == '0);

    // R7/R2: a channel whose raw input agreed with its level keeps it.
    p_agree_holds_r2: assert property (@(posedge clk) disable iff (rst)
        ((~($past(raw_i) ^ $past(level_o))) & (level_o ^ $past(level_o))) == '0);

    // R6: no pulse lasts two cycles on the same channel.
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(event_o) & event_o) == '0);

endmodule

bind contact_debouncer contact_debouncer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .raw_i   (raw_i),
    .level_o (level_o),
    .event_o (event_o)
);

// File: tb/contact_debouncer_test.sv
module contact_debouncer_test;
    localparam int NUM_CH     = 32;
    localparam int TICK_DIV   = 4;
    localparam int BASE_TICKS = 2;
    localparam int NVEC       = 6;

    // {period code, raw pattern}
    localparam logic [34:0] VEC [NVEC] = '{
        {3'd1, 32'h0000_00FF},
        {3'd0, 32'hFFFF_0000},
        {3'd2, 32'hA5A5_5A5A},
        {3'd3, 32'h0000_0000},
        {3'd4, 32'h8000_0001},
        {3'd1, 32'hFFFF_FFFF}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        sel = 3'd0;
    logic [NUM_CH-1:0] raw = '0;
    logic [NUM_CH-1:0] level_o;
    logic [NUM_CH-1:0] event_o;

    int checks = 0;
    int errors = 0;
    int evt_total = 0;
    bit done = 1'b0;

    contact_debouncer #(
        .NUM_CH(NUM_CH), .TICK_DIV(TICK_DIV), .BASE_TICKS(BASE_TICKS)
    ) uut (
        .clk          (clk),
        .rst          (rst),
        .period_sel_i (sel),
        .raw_i        (raw),
        .level_o      (level_o),
        .event_o      (event_o)
    );

    always #4 clk = ~clk;

    function automatic int n_ticks(logic [2:0] c);
        case (c)
            3'd0: return BASE_TICKS * 1;
            3'd1: return BASE_TICKS * 2;
            3'd2: return BASE_TICKS * 4;
            3'd3: return BASE_TICKS * 8;
            3'd4: return BASE_TICKS * 32;
            3'd5: return BASE_TICKS * 128;
            3'd6: return BASE_TICKS * 512;
            default: return BASE_TICKS * 4096;
        endcase
    endfunction

    function automatic int pop(logic [NUM_CH-1:0] v);
        int c = 0;
        for (int i = 0; i < NUM_CH; i++) c += int'(v[i]);
        return c;
    endfunction

    // Count event pulses, one per high bit per cycle.
    always @(negedge clk) begin
        if (rst) evt_total = 0;
        else evt_total = evt_total + pop(event_o);
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NUM_CH-1:0] prev;
        logic [NUM_CH-1:0] tgt;
        int base;
        int n;

        step(4);
        check(level_o == '0, "R1", "level in reset", level_o, '0);
        check(event_o == '0, "R1", "event in reset", event_o, '0);
        rst = 1'b0;
        step(20);
        check(level_o == '0, "R1", "level idle after reset", level_o, '0);

        // Table walk: R3, R4, R5, R6 over several codes and patterns.
        for (int k = 0; k < NVEC; k++) begin
            sel = VEC[k][34:32];
            step(3);
            prev = level_o;
            base = evt_total;
            raw  = VEC[k][31:0];
            n    = n_ticks(sel);
            step(TICK_DIV * (n - 1) - 1);
            check(level_o == prev, "R3", "held before period", level_o, prev);
            step(TICK_DIV + 3);
            check(level_o == raw, "R4", "level after period", level_o, raw);
            check(evt_total - base == pop(prev ^ raw), "R6", "event count",
                  evt_total - base, pop(prev ^ raw));
        end

        // R2: bounces shorter than a period never report, even in sum.
        sel = 3'd2;
        n   = n_ticks(3'd2);
        step(3);
        prev = level_o;
        base = evt_total;
        for (int b = 0; b < 4; b++) begin
            raw = prev ^ 32'h0000_0020;
            step(TICK_DIV * (n - 1) - 4);
            raw = prev;
            step(2);
        end
        check(level_o == prev, "R2", "bounced channel unchanged", level_o, prev);
        check(evt_total == base, "R2", "no event on bounce", evt_total, base);
        raw = prev ^ 32'h0000_0020;
        step(TICK_DIV * (n - 1) - 1);
        check(level_o == prev, "R2", "full period needed after bounce", level_o, prev);
        step(TICK_DIV + 3);
        check(level_o == raw, "R2", "steady level reported", level_o, raw);

        // R5: switch from the longest to the shortest code mid-window.
        sel = 3'd7;
        step(3);
        prev = level_o;
        raw  = prev ^ 32'h0000_0200;
        step(100);
        check(level_o == prev, "R5", "long window still running", level_o, prev);
        sel = 3'd0;
        step(2 + TICK_DIV + 2);
        check(level_o == raw, "R5", "shorter code applies at once", level_o, raw);

        // R4: longest setting on one channel.
        sel = 3'd7;
        n   = n_ticks(3'd7);
        step(3);
        prev = level_o;
        raw  = prev ^ 32'h0000_0001;
        step(TICK_DIV * (n - 1) - 1);
        check(level_o == prev, "R4", "longest code not early", level_o, prev);
        step(TICK_DIV + 3);
        check(level_o == raw, "R4", "longest code reports", level_o, raw);

        // R1: reset in the middle of a window.
        sel = 3'd3;
        n   = n_ticks(3'd3);
        step(3);
        raw = ~level_o;
        step(10);
        rst = 1'b1;
        step(4);
        check(level_o == '0 && event_o == '0, "R1", "mid-window reset clears",
              level_o, '0);
        raw = '0;
        rst = 1'b0;
        step(3);
        tgt = 32'h0001_0000;
        raw = tgt;
        step(TICK_DIV * (n - 1) - 1);
        check(level_o == '0, "R1", "full period after reset", level_o, '0);
        step(TICK_DIV + 3);
        check(level_o == tgt, "R1", "report after reset", level_o, tgt);
        check(event_o == '0, "R6", "pulse gone", event_o, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule